// File: doc/BRIEF.md
# NOR Flash Command Interface

This block models the command decoder and write state machine of a 16-bit parallel NOR flash. Each bus write strobe is read as one step of a command. The low byte of the write data carries the opcode. The upper address bits and the full data word carry the operands. The block keeps a read mode, and that mode decides what a bus read returns: array contents, the status register, the identification codes, or a small query area. The bus read path is combinational from `bus_addr`.

Program and erase jobs go to an internal engine. The engine holds the word array in registers, is busy for a parameter number of clock cycles, and applies the job on its last busy cycle. A job can be paused and resumed. Error flags stay set until software clears them. While any error flag is set, new program and erase setups are refused. The `lock_mask` input marks which blocks are protected. A block is the group of words that share `bus_addr[AW-1:BLK_LSB]`.

The write state machine has six states:
- ST_IDLE: no command in progress.
- ST_PGM1: waiting for the single-word data write.
- ST_PGMN: collecting the words of a double or quad program.
- ST_ERSET: waiting for the erase confirm.
- ST_RUN: the engine is running.
- ST_HOLD: the job is suspended.

The transitions are:
- ST_IDLE goes to ST_PGM1 on 40h or 10h, to ST_PGMN on 30h or 56h, and to ST_ERSET on 20h. Each of these is taken only while no error flag is set.
- ST_PGM1 goes to ST_RUN on the data write, or back to ST_IDLE if the block is locked.
- ST_PGMN goes to ST_RUN on its last word when the addresses are valid and the block is unlocked, and to ST_IDLE otherwise.
- ST_ERSET goes to ST_RUN on D0h for an unlocked block, and to ST_IDLE otherwise.
- ST_RUN goes to ST_HOLD on B0h, and to ST_IDLE when the engine finishes.
- ST_HOLD goes to ST_RUN on D0h. It goes to ST_IDLE if the engine is no longer busy.

Top module: `nfc_top`

## Requirements
- R1: After reset every array word reads FFFFh in array mode, and the status register reads 0080h.
- R2: In ST_IDLE or ST_HOLD, writing FFh selects array reads, 70h selects status reads, 90h selects identification reads and 98h selects query reads. Identification reads return 0020h at even addresses and 88BAh at odd addresses. Query reads return 0051h, 0052h and 0059h at addresses 10h, 11h and 12h.
- R3: The single-word program is 40h or 10h followed by one write of the address and data. It stores old AND data, and it switches reads to status.
- R4: Status bit 7 reads 0 for exactly PROG_CYCLES cycles after a program is accepted, then reads 1.
- R5: The double program is 30h followed by two writes. The first address has bit 0 equal to 0. The second address equals the first with bit 0 set. Any other address sets status bit 4 and writes nothing.
- R6: The quad program is 56h followed by four writes. The k-th write, counting from 0, carries an address whose bits 1:0 equal k and whose upper bits equal those of the first write. A violation sets status bit 4 and writes nothing.
- R7: The erase is 20h followed by D0h. It sets every word of the addressed block to FFFFh and leaves the other blocks unchanged.
- R8: After 20h, any write whose low byte is not D0h sets status bits 5 and 4 and starts nothing.
- R9: A program or erase aimed at a block whose `lock_mask` bit is 1 sets status bit 1 and leaves the array unchanged.
- R10: B0h during a running job pauses it. Status then reads bit 7 = 1, with bit 6 = 1 for an erase or bit 2 = 1 for a program. The array is not changed and array reads are allowed. D0h resumes the job, which then completes.
- R11: While status bit 5, 4 or 1 is set, program and erase setup opcodes are ignored.
- R12: Writing 50h in ST_IDLE clears status bits 5, 4 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | AW | Word address for writes and reads |
| bus_wdata | input | 16 | Write data; the low byte is the opcode |
| lock_mask | input | 2**(AW-BLK_LSB) | 1 marks a protected block |
| bus_rdata | output | 16 | Read data for bus_addr in the current read mode |

## Verification
The assertions assume that `bus_we` is a one-cycle strobe. They also assume that `bus_addr` and `bus_wdata` are stable in the cycle the strobe is sampled, and that `lock_mask` does not change while a job is running. The bench drives every input at the falling edge and keeps `lock_mask` fixed across each job. It sends only data words whose low byte matches no opcode when those words arrive in ST_IDLE.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_PGM1, ST_PGMN, ST_ERSET, ST_RUN, ST_HOLD
    } fsm_t;

    typedef enum logic [1:0] {
        RM_ARRAY, RM_STATUS, RM_SIG, RM_QUERY
    } rmode_t;

    localparam logic [7:0] OP_READ     = 8'hFF;
    localparam logic [7:0] OP_SIG      = 8'h90;
    localparam logic [7:0] OP_QRY      = 8'h98;
    localparam logic [7:0] OP_RSR      = 8'h70;
    localparam logic [7:0] OP_CLR      = 8'h50;
    localparam logic [7:0] OP_PGM      = 8'h40;
    localparam logic [7:0] OP_PGM_ALT  = 8'h10;
    localparam logic [7:0] OP_PGM2     = 8'h30;
    localparam logic [7:0] OP_PGM4     = 8'h56;
    localparam logic [7:0] OP_ERS      = 8'h20;
    localparam logic [7:0] OP_GO       = 8'hD0;
    localparam logic [7:0] OP_SUSP     = 8'hB0;

    localparam logic [15:0] ID_MFR = 16'h0020;
    localparam logic [15:0] ID_DEV = 16'h88BA;
endpackage

// File: rtl/nfc_engine.sv
module nfc_engine #(
    parameter int AW           = 8,
    parameter int BLK_LSB      = 4,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  run,
    input  logic                  job_erase,
    input  logic [3:0]            job_mask,
    input  logic [3:0][AW-1:0]    job_addr,
    input  logic [3:0][15:0]      job_data,
    input  logic [AW-1:0]         rd_addr,
    output logic [15:0]           rd_data,
    output logic                  busy
);
    localparam int DEPTH = 1 << AW;
    localparam int MAXC  = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CW    = $clog2(MAXC + 1);

    logic [15:0]   mem [DEPTH];
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= job_erase ? CW'(ERASE_CYCLES) : CW'(PROG_CYCLES);
        end else if (busy && run) begin
            if (cnt == CW'(1)) begin
                busy <= 1'b0;
                if (job_erase) begin
                    for (int i = 0; i < DEPTH; i++)
                        if ((AW'(i) >> BLK_LSB) == (job_addr[0] >> BLK_LSB))
                            mem[i] <= '1;
                end else begin
                    for (int s = 0; s < 4; s++)
                        if (job_mask[s])
                            mem[job_addr[s]] <= mem[job_addr[s]] & job_data[s];
                end
            end else begin
                cnt <= cnt - CW'(1);
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/nfc_cmd.sv
module nfc_cmd
    import nfc_pkg::*;
#(
    parameter int AW      = 8,
    parameter int BLK_LSB = 4,
    localparam int NBLK   = 1 << (AW - BLK_LSB)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [AW-1:0]      addr,
    input  logic [15:0]        wdata,
    input  logic [NBLK-1:0]    lock_mask,
    input  logic               eng_busy,
    output logic               eng_start,
    output logic               eng_run,
    output logic               job_erase,
    output logic [3:0]         job_mask,
    output logic [3:0][AW-1:0] job_addr,
    output logic [3:0][15:0]   job_data,
    output rmode_t             rmode,
    output logic [7:0]         sr,
    output fsm_t               st
);
    fsm_t        nxt;
    logic [7:0]  op;
    logic        e_err, p_err, l_err, errs, locked;
    logic        quad_q, bad_q, last, pair_ok;
    logic [1:0]  wcnt;
    logic [AW-1:0] lowm, ref_a;

    assign op     = wdata[7:0];
    assign errs   = e_err | p_err | l_err;
    assign locked = lock_mask[addr[AW-1:BLK_LSB]];
    assign lowm   = quad_q ? AW'(3) : AW'(1);
    assign ref_a  = (wcnt == 2'd0) ? addr : job_addr[0];
    assign last   = (wcnt == (quad_q ? 2'd3 : 2'd1));
    assign pair_ok = ((addr & ~lowm) == (ref_a & ~lowm)) && ((addr & lowm) == AW'(wcnt));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // next state and engine start
    always_comb begin
        nxt       = st;
        eng_start = 1'b0;
        unique case (st)
            ST_IDLE:
                if (we && !errs) begin
                    if (op == OP_PGM || op == OP_PGM_ALT)   nxt = ST_PGM1;
                    else if (op == OP_PGM2 || op == OP_PGM4) nxt = ST_PGMN;
                    else if (op == OP_ERS)                  nxt = ST_ERSET;
                end
            ST_PGM1:
                if (we) begin
                    nxt       = locked ? ST_IDLE : ST_RUN;
                    eng_start = !locked;
                end
            ST_PGMN:
                if (we && last) begin
                    eng_start = !bad_q && pair_ok && !locked;
                    nxt       = eng_start ? ST_RUN : ST_IDLE;
                end
            ST_ERSET:
                if (we) begin
                    eng_start = (op == OP_GO) && !locked;
                    nxt       = eng_start ? ST_RUN : ST_IDLE;
                end
            ST_RUN:
                if (!eng_busy)                 nxt = ST_IDLE;
                else if (we && op == OP_SUSP)  nxt = ST_HOLD;
            ST_HOLD:
                if (!eng_busy)                 nxt = ST_IDLE;
                else if (we && op == OP_GO)    nxt = ST_RUN;
            default: nxt = ST_IDLE;
        endcase
    end

    // datapath: read mode, operands, error flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rmode <= RM_ARRAY;
            {e_err, p_err, l_err, quad_q, bad_q, job_erase} <= '0;
            wcnt     <= '0;
            job_mask <= '0;
            job_addr <= '0;
            job_data <= '0;
        end else if (we) begin
            unique case (st)
                ST_IDLE, ST_HOLD: begin
                    if (op == OP_READ)     rmode <= RM_ARRAY;
                    else if (op == OP_SIG) rmode <= RM_SIG;
                    else if (op == OP_QRY) rmode <= RM_QUERY;
                    else if (op == OP_RSR || (st == ST_HOLD && op == OP_GO)) rmode <= RM_STATUS;
                    if (st == ST_IDLE && op == OP_CLR) {e_err, p_err, l_err} <= '0;
                    if (st == ST_IDLE && !errs && (op == OP_PGM || op == OP_PGM_ALT ||
                        op == OP_PGM2 || op == OP_PGM4 || op == OP_ERS)) begin
                        rmode     <= RM_STATUS;
                        quad_q    <= (op == OP_PGM4);
                        job_erase <= (op == OP_ERS);
                        job_mask  <= (op == OP_PGM4) ? 4'b1111 :
                                     (op == OP_PGM2) ? 4'b0011 : 4'b0001;
                        wcnt      <= '0;
                        bad_q     <= 1'b0;
                    end
                end
                ST_PGM1: begin
                    job_addr[0] <= addr;
                    job_data[0] <= wdata;
                    if (locked) l_err <= 1'b1;
                end
                ST_PGMN: begin
                    job_addr[wcnt] <= addr;
                    job_data[wcnt] <= wdata;
                    wcnt  <= wcnt + 2'd1;
                    bad_q <= bad_q | !pair_ok;
                    if (last) begin
                        if (bad_q || !pair_ok) p_err <= 1'b1;
                        else if (locked)       l_err <= 1'b1;
                    end
                end
                ST_ERSET: begin
                    job_addr[0] <= addr;
                    if (op != OP_GO)  {e_err, p_err} <= 2'b11;
                    else if (locked)  l_err <= 1'b1;
                end
                ST_RUN:
                    if (op == OP_RSR || op == OP_SUSP) rmode <= RM_STATUS;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        eng_run = (st != ST_HOLD);
        sr      = {!(eng_busy && st != ST_HOLD),
                   st == ST_HOLD && job_erase,
                   e_err, p_err, 1'b0,
                   st == ST_HOLD && !job_erase,
                   l_err, 1'b0};
    end
endmodule

// File: rtl/nfc_rdmux.sv
module nfc_rdmux
    import nfc_pkg::*;
#(
    parameter int AW = 8
) (
    input  rmode_t        rmode,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   arr_data,
    input  logic [7:0]    sr,
    output logic [15:0]   rdata
);
    always_comb begin
        unique case (rmode)
            RM_ARRAY:  rdata = arr_data;
            RM_STATUS: rdata = {8'h00, sr};
            RM_SIG:    rdata = addr[0] ? ID_DEV : ID_MFR;
            RM_QUERY:
                if (addr == AW'(16))      rdata = 16'h0051;
                else if (addr == AW'(17)) rdata = 16'h0052;
                else if (addr == AW'(18)) rdata = 16'h0059;
                else                      rdata = 16'h0000;
            default:   rdata = 16'h0000;
        endcase
    end
endmodule

// File: rtl/nfc_top.sv
module nfc_top
    import nfc_pkg::*;
#(
    parameter int AW           = 8,
    parameter int BLK_LSB      = 4,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 20,
    localparam int NBLK        = 1 << (AW - BLK_LSB)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [15:0]     bus_wdata,
    input  logic [NBLK-1:0] lock_mask,
    output logic [15:0]     bus_rdata
);
    logic               eng_start, eng_run, eng_busy, job_erase;
    logic [3:0]         job_mask;
    logic [3:0][AW-1:0] job_addr;
    logic [3:0][15:0]   job_data;
    logic [15:0]        arr_data;
    logic [7:0]         sr;
    rmode_t             rmode;
    fsm_t               st;

    nfc_cmd #(.AW(AW), .BLK_LSB(BLK_LSB)) u_cmd (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .lock_mask(lock_mask), .eng_busy(eng_busy), .eng_start(eng_start),
        .eng_run(eng_run), .job_erase(job_erase), .job_mask(job_mask),
        .job_addr(job_addr), .job_data(job_data), .rmode(rmode), .sr(sr), .st(st)
    );

    nfc_engine #(.AW(AW), .BLK_LSB(BLK_LSB), .PROG_CYCLES(PROG_CYCLES),
                 .ERASE_CYCLES(ERASE_CYCLES)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .run(eng_run),
        .job_erase(job_erase), .job_mask(job_mask), .job_addr(job_addr),
        .job_data(job_data), .rd_addr(bus_addr), .rd_data(arr_data), .busy(eng_busy)
    );

    nfc_rdmux #(.AW(AW)) u_rd (
        .rmode(rmode), .addr(bus_addr), .arr_data(arr_data), .sr(sr), .rdata(bus_rdata)
    );
endmodule

// File: rtl/nfc_chk.sv
module nfc_chk
    import nfc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_we,
    input logic [15:0] bus_wdata,
    input fsm_t        st,
    input logic [7:0]  sr,
    input logic        eng_start,
    input logic        eng_busy,
    input logic        eng_run
);
    // R4: an accepted job makes the ready bit drop on the next cycle
    a_r4_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !sr[7]);

    // R10: a paused job cannot finish
    a_r10_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && !eng_run) |=> eng_busy);

    // R8: wrong confirm after erase setup flags a sequence error
    a_r8_seq_error: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERSET && bus_we && bus_wdata[7:0] != OP_GO) |=> (sr[5] && sr[4]));

    // R11: no job is launched while an error flag is pending
    a_r11_no_start_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (sr[5:4] == 2'b00 && !sr[1]));

    // R12: clear status drops all error flags
    a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && bus_we && bus_wdata[7:0] == OP_CLR) |=> (sr[5:4] == 2'b00 && !sr[1]));
endmodule

bind nfc_top nfc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wdata(bus_wdata), .st(st),
    .sr(sr), .eng_start(eng_start), .eng_busy(eng_busy), .eng_run(eng_run)
);

// File: tb/tb_nfc_top.sv
`timescale 1ns/1ps
module tb_nfc_top;
    localparam int AW = 8;
    localparam int BLK_LSB = 4;
    localparam int PROG_CYCLES = 8;
    localparam int ERASE_CYCLES = 20;
    localparam int NBLK = 1 << (AW - BLK_LSB);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_we = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [15:0]     bus_wdata = '0;
    logic [NBLK-1:0] lock_mask = '0;
    logic [15:0]     bus_rdata;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    nfc_top #(.AW(AW), .BLK_LSB(BLK_LSB), .PROG_CYCLES(PROG_CYCLES),
              .ERASE_CYCLES(ERASE_CYCLES)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .lock_mask(lock_mask), .bus_rdata(bus_rdata));

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
    endtask

    task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    // polls status; returns number of busy reads
    task automatic wait_ready(output int n);
        logic [15:0] v;
        n = 0;
        for (int i = 0; i < 300; i++) begin
            rd('0, v);
            if (v[7]) break;
            n++;
        end
    endtask

    task automatic t_reset;
        rd_chk("R1 array after reset", 8'h05, 16'hFFFF);
        rd_chk("R1 array top word", 8'hFF, 16'hFFFF);
        wr('0, 16'h0070);
        rd_chk("R1 status after reset", 8'h00, 16'h0080);
        wr('0, 16'h00FF);
    endtask

    task automatic t_modes;
        wr('0, 16'h0090);
        rd_chk("R2 mfr code", 8'h00, 16'h0020);
        rd_chk("R2 device code", 8'h01, 16'h88BA);
        rd_chk("R2 mfr code even addr", 8'h20, 16'h0020);
        wr('0, 16'h0098);
        rd_chk("R2 query 10h", 8'h10, 16'h0051);
        rd_chk("R2 query 12h", 8'h12, 16'h0059);
        wr('0, 16'h0070);
        rd_chk("R2 status mode", 8'h00, 16'h0080);
        wr('0, 16'h00FF);
        rd_chk("R2 array mode", 8'h05, 16'hFFFF);
    endtask

    task automatic t_single;
        int n;
        wr('0, 16'h0040);
        wr(8'h21, 16'h12A5);
        rd_chk("R4 busy right after accept", 8'h00, 16'h0000);
        wait_ready(n);
        check("R4 busy cycles", 16'(n + 1), 16'(PROG_CYCLES));
        rd_chk("R3 auto status mode", 8'h21, 16'h0080);
        wr('0, 16'h00FF);
        rd_chk("R3 programmed word", 8'h21, 16'h12A5);
        wr('0, 16'h0010);
        wr(8'h21, 16'hF00F);
        wait_ready(n);
        wr('0, 16'h00FF);
        rd_chk("R3 program ANDs old data", 8'h21, 16'h1005);
    endtask

    task automatic t_double;
        int n;
        wr('0, 16'h0030);
        wr(8'h30, 16'h1111);
        wr(8'h31, 16'h2222);
        wait_ready(n);
        wr('0, 16'h00FF);
        rd_chk("R5 double word 0", 8'h30, 16'h1111);
        rd_chk("R5 double word 1", 8'h31, 16'h2222);
        wr('0, 16'h0030);
        wr(8'h40, 16'h3333);
        wr(8'h51, 16'h4444);
        rd_chk("R5 pairing error status", 8'h00, 16'h0090);
        wr('0, 16'h00FF);
        rd_chk("R5 no write on bad pair a", 8'h40, 16'hFFFF);
        rd_chk("R5 no write on bad pair b", 8'h51, 16'hFFFF);
        wr('0, 16'h0050);
    endtask

    task automatic t_quad;
        int n;
        wr('0, 16'h0056);
        for (int k = 0; k < 4; k++) wr(8'h64 + 8'(k), 16'h0A01 + 16'(k));
        wait_ready(n);
        wr('0, 16'h00FF);
        for (int k = 0; k < 4; k++) rd_chk("R6 quad word", 8'h64 + 8'(k), 16'h0A01 + 16'(k));
        wr('0, 16'h0056);
        wr(8'h70, 16'h0101);
        wr(8'h71, 16'h0202);
        wr(8'h73, 16'h0303);
        wr(8'h72, 16'h0404);
        rd_chk("R6 quad order error status", 8'h00, 16'h0090);
        wr('0, 16'h00FF);
        rd_chk("R6 no write on bad quad", 8'h72, 16'hFFFF);
        wr('0, 16'h0050);
    endtask

    task automatic t_erase;
        int n;
        wr('0, 16'h0020);
        wr(8'h6A, 16'h00D0);
        wait_ready(n);
        wr('0, 16'h00FF);
        rd_chk("R7 erased word 64", 8'h64, 16'hFFFF);
        rd_chk("R7 erased word 67", 8'h67, 16'hFFFF);
        rd_chk("R7 other block kept", 8'h31, 16'h2222);
    endtask

    task automatic t_seqerr;
        int n;
        wr('0, 16'h0020);
        wr('0, 16'h00FF);
        rd_chk("R8 sequence error status", 8'h00, 16'h00B0);
        wr('0, 16'h0040);
        wr(8'h80, 16'h0F0F);
        wr('0, 16'h00FF);
        rd_chk("R11 setup ignored while error", 8'h80, 16'hFFFF);
        wr('0, 16'h0070);
        wr('0, 16'h0050);
        rd_chk("R12 status cleared", 8'h00, 16'h0080);
        wr('0, 16'h0040);
        wr(8'h80, 16'h0F0F);
        wait_ready(n);
        wr('0, 16'h00FF);
        rd_chk("R12 program works after clear", 8'h80, 16'h0F0F);
    endtask

    task automatic t_lock;
        int n;
        wr('0, 16'h0040);
        wr(8'hF3, 16'h5A5A);
        wait_ready(n);
        lock_mask = NBLK'(1) << 15;
        wr('0, 16'h0040);
        wr(8'hF3, 16'h0000);
        rd_chk("R9 locked program status", 8'h00, 16'h0082);
        wr('0, 16'h00FF);
        rd_chk("R9 locked word unchanged", 8'hF3, 16'h5A5A);
        wr('0, 16'h0050);
        wr('0, 16'h0020);
        wr(8'hF0, 16'h00D0);
        rd_chk("R9 locked erase status", 8'h00, 16'h0082);
        wr('0, 16'h00FF);
        rd_chk("R9 locked block not erased", 8'hF3, 16'h5A5A);
        wr('0, 16'h0050);
        lock_mask = '0;
    endtask

    task automatic t_suspend;
        int n;
        wr('0, 16'h0040);
        wr(8'h25, 16'h3C3C);
        wait_ready(n);
        wr('0, 16'h0020);
        wr(8'h20, 16'h00D0);
        wr('0, 16'h00B0);
        rd_chk("R10 erase suspended status", 8'h00, 16'h00C0);
        repeat (40) @(negedge clk);
        rd_chk("R10 still suspended", 8'h00, 16'h00C0);
        wr('0, 16'h00FF);
        rd_chk("R10 array read while paused", 8'h25, 16'h3C3C);
        wr('0, 16'h00D0);
        rd_chk("R10 resumed busy", 8'h00, 16'h0000);
        wait_ready(n);
        wr('0, 16'h00FF);
        rd_chk("R10 erase completes after resume", 8'h25, 16'hFFFF);
        wr('0, 16'h0040);
        wr(8'h26, 16'h0F0F);
        wr('0, 16'h00B0);
        rd_chk("R10 program suspended status", 8'h00, 16'h0084);
        wr('0, 16'h00D0);
        wait_ready(n);
        wr('0, 16'h00FF);
        rd_chk("R10 program completes after resume", 8'h26, 16'h0F0F);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_modes;
        t_single;
        t_double;
        t_quad;
        t_erase;
        t_seqerr;
        t_lock;
        t_suspend;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule